// File: doc/BRIEF.md
# Latching PHY Status Register

This block is the read-only status word of an Ethernet PHY management register file. It combines fixed capability flags with live and event-driven status. Auto-negotiation completion is followed level by level. Remote fault and jabber are caught by sticky bits that hold an event until software has read it. Link status works the other way round: any failure pulls it low, and it stays low until a good link and a management read have both been seen.

The management logic decodes the register address and presents a one-cycle read strobe. The current word is always on `rd_data_o`. A read returns the word as it stood before that read's side effects. Those side effects are the clearing of the sticky-high bits and the re-arming of the link bit, and they take effect on the next clock edge. The 10 Mb/s jabber detector is honoured only while the PHY is not running at 100 Mb/s.

Top module: `phy_stat_reg`

## Requirements
- R1: The capability bits read constant: bit 15 = 0; bits 14, 13, 12, 11 = 1; bit 6 = 1; bit 3 = 1; bit 0 = 1.
- R2: Bits 10 to 7 always read 0.
- R3: Bit 5 equals `an_done_i` as sampled at the previous clock edge.
- R4: Bit 4 becomes 1 on the cycle after `rmt_fault_i` is high. It then holds 1 until a read strobe clears it.
- R5: During a read-strobe cycle, `rd_data_o` shows the value from before the read. The clearing caused by the read appears on the following cycle.
- R6: If an event arrives in the same cycle as a clearing read, the event wins, and the sticky-high bit reads 1 afterwards.
- R7: Bit 1 becomes 1 on the cycle after `jabber_i` is high while `speed_100_i` = 0. It then holds until it is read.
- R8: `jabber_i` has no effect while `speed_100_i` = 1.
- R9: Bit 2 reads 0 on the cycle after `link_fail_i` is high. This holds even if a good link and a read occur in the same cycle.
- R10: When bit 2 is 0, it rises one cycle after `link_good_i` is high in a cycle where a read strobe is present or has occurred since the last failure or reset. A good link with no such read leaves it at 0.
- R11: Reset is synchronous and active-low. It clears bits 5, 4, 2 and 1 and the link's read-seen memory, so the word reads 16'h7849.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_good_i | input | 1 | Link detector reports a good link (level) |
| link_fail_i | input | 1 | Link detector reports a failure (event) |
| rmt_fault_i | input | 1 | Far-end or partner remote fault seen (event) |
| jabber_i | input | 1 | 10 Mb/s jabber condition (event) |
| an_done_i | input | 1 | Auto-negotiation finished (level) |
| speed_100_i | input | 1 | 1 = operating at 100 Mb/s |
| rd_stb_i | input | 1 | One-cycle read of this register |
| rd_data_o | output | 16 | Current register word |

## Verification
An event can arrive in the same cycle as a management read. The bench provokes this deliberately: a remote fault or jabber pulse together with a read strobe, and a link failure together with a good link and a read. It then checks the word one cycle later. The event must prevail in each case: the sticky bit stays set, and the link bit stays clear. The bench also samples the word inside the read cycle itself, to confirm that the value before the clear is what gets returned.

// File: rtl/phy_stat_pkg.sv
// Shared bit positions and constant content of the PHY status word.
// Assumes a 16-bit management register.
package phy_stat_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned POS_AN  = 5;
    localparam int unsigned POS_RF  = 4;
    localparam int unsigned POS_LNK = 2;
    localparam int unsigned POS_JAB = 1;
    // Capability flags: 100FD,100HD,10FD,10HD, preamble suppression, AN ability, extended.
    localparam logic [WORD_W-1:0] CAP_WORD = 16'h7849;
endpackage

// File: rtl/stat_latch_hi.sv
// Sticky-high status bit: sets on an event, clears on the edge after a read.
// Assumes rd_stb is a single-cycle strobe. An event in the read cycle wins.
module stat_latch_hi (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_stb,
    output logic q
);
    // Hold the event until it is read; an event takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= evt | (q & ~rd_stb);
    end

    // R4 R7
    // sticky_set_chk
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> q);
    // R4
    // sticky_hold_chk
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (q && !rd_stb) |=> q);
    // R5
    // sticky_clr_chk
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && !evt) |=> !q);
endmodule

// File: rtl/stat_link_lo.sv
// Sticky-low link bit: a failure clears it. It rises again only after a good
// link has been seen and a read has occurred since the failure.
// Assumes link_good is a level and link_fail an event pulse.
module stat_link_lo (
    input  logic clk,
    input  logic rst_n,
    input  logic link_good,
    input  logic link_fail,
    input  logic rd_stb,
    output logic q
);
    logic rd_seen;
    logic armed;

    assign armed = rd_seen | rd_stb;

    // Remember a read since the last failure or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_seen <= 1'b0;
        else if (link_fail) rd_seen <= 1'b0;
        else if (rd_stb)    rd_seen <= 1'b1;
    end

    // Link bit: failure dominates; rises on a good link once armed by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~link_fail & (q | (link_good & armed));
    end

    // R9
    // link_fail_clr_chk
    link_fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) link_fail |=> !q);
    // R10
    // link_need_read_chk
    link_need_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && !rd_stb && !rd_seen) |=> !q);
    // R10
    // link_rise_chk
    link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_fail && link_good && rd_stb) |=> q);
endmodule

// File: rtl/phy_stat_reg.sv
// PHY status register: capability constants merged with the live and sticky
// status bits. Read data is combinational from the held state, so a read
// returns the value from before its own clearing effect.
module phy_stat_reg
    import phy_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_good_i,
    input  logic              link_fail_i,
    input  logic              rmt_fault_i,
    input  logic              jabber_i,
    input  logic              an_done_i,
    input  logic              speed_100_i,
    input  logic              rd_stb_i,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam int unsigned N_STICKY = 2;

    logic                an_q;
    logic                lnk_q;
    logic [N_STICKY-1:0] stk_evt;
    logic [N_STICKY-1:0] stk_q;

    // Jabber only matters in 10 Mb/s mode.
    assign stk_evt[0] = rmt_fault_i;
    assign stk_evt[1] = jabber_i & ~speed_100_i;

    // Register the auto-negotiation completion level.
    always_ff @(posedge clk) begin
        if (!rst_n) an_q <= 1'b0;
        else        an_q <= an_done_i;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        stat_latch_hi u_hi (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (stk_evt[i]),
            .rd_stb (rd_stb_i),
            .q      (stk_q[i])
        );
    end

    stat_link_lo u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_good (link_good_i),
        .link_fail (link_fail_i),
        .rd_stb    (rd_stb_i),
        .q         (lnk_q)
    );

    // Assemble the read word from the constants and the status bits.
    always_comb begin
        rd_data_o          = CAP_WORD;
        rd_data_o[POS_AN]  = an_q;
        rd_data_o[POS_RF]  = stk_q[0];
        rd_data_o[POS_LNK] = lnk_q;
        rd_data_o[POS_JAB] = stk_q[1];
    end

    // R3
    // an_follow_chk
    an_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_done_i |=> rd_data_o[POS_AN]);
    // R8
    // jab_fast_ignored_chk
    jab_fast_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100_i && !rd_data_o[POS_JAB]) |=> !rd_data_o[POS_JAB]);
endmodule

// File: tb/sim_phy_stat_reg.sv
`timescale 1ns/1ps
module sim_phy_stat_reg;
    localparam logic [15:0] C  = 16'h7849;
    localparam logic [15:0] AN = 16'h0020;
    localparam logic [15:0] RF = 16'h0010;
    localparam logic [15:0] LK = 16'h0004;
    localparam logic [15:0] JB = 16'h0002;
    // stimulus bits {good,fail,rf,jab,an,s100,rd}
    localparam logic [6:0] GD = 7'b1000000, FL = 7'b0100000, RFE = 7'b0010000,
                           JE = 7'b0001000, ANE = 7'b0000100, S1 = 7'b0000010,
                           RD = 7'b0000001;

    logic clk = 0, rst_n = 0;
    logic link_good_i = 0, link_fail_i = 0, rmt_fault_i = 0, jabber_i = 0;
    logic an_done_i = 0, speed_100_i = 0, rd_stb_i = 0;
    logic [15:0] rd_data_o;
    int checks = 0, errors = 0;
    logic [15:0] q_exp[$];
    string q_tag[$];
    event ev;
    bit done = 0;

    always #2 clk = ~clk;

    phy_stat_reg u0 (.*);

    // Monitor: pop an expected word and compare it with the output.
    initial forever begin
        @(ev);
        while (q_exp.size() > 0) begin
            logic [15:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (rd_data_o !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, rd_data_o, e);
            end
        end
    end

    // Driver: apply one cycle of stimulus; optionally check in-cycle, then after the edge.
    task automatic step(input logic [6:0] s, input bit pre, input logic [15:0] pre_e,
                        input logic [15:0] post_e, input string tag);
        @(negedge clk);
        {link_good_i, link_fail_i, rmt_fault_i, jabber_i, an_done_i, speed_100_i, rd_stb_i} = s;
        #1;
        if (pre) begin
            q_exp.push_back(pre_e); q_tag.push_back({tag, " (read cycle)"}); ->ev; #0;
        end
        @(posedge clk); #1;
        q_exp.push_back(post_e); q_tag.push_back(tag); ->ev;
    endtask

    initial begin
        rst_n = 0;
        step(ANE | RFE | JE, 0, 0, C, "R11 reset word");
        rst_n = 1;
        step(0, 0, 0, C, "R1 R2 capability and reserved");
        step(ANE, 0, 0, C | AN, "R3 an set");
        step(0, 0, 0, C, "R3 an clear");
        step(RFE, 0, 0, C | RF, "R4 rf set");
        step(0, 0, 0, C | RF, "R4 rf hold");
        step(RD, 1, C | RF, C, "R5 rf read clears next cycle");
        step(RFE | RD, 0, 0, C | RF, "R6 rf event beats read");
        step(RD, 0, 0, C, "R4 rf cleared");
        step(JE, 0, 0, C | JB, "R7 jabber at 10M");
        step(0, 0, 0, C | JB, "R7 jabber hold");
        step(RD, 1, C | JB, C, "R5 jabber read");
        step(JE | S1, 0, 0, C, "R8 jabber at 100M ignored");
        step(S1, 0, 0, C, "R8 still clear");
        step(JE, 0, 0, C | JB, "R7 jabber set again");
        step(JE | RD, 0, 0, C | JB, "R6 jabber event beats read");
        step(GD, 0, 0, C | JB | LK, "R10 good link after earlier reads");
        step(GD | FL, 0, 0, C | JB, "R9 failure clears link");
        step(GD, 0, 0, C | JB, "R10 good without read stays low");
        step(GD, 0, 0, C | JB, "R10 still low");
        step(GD | RD, 1, C | JB, C | LK, "R10 good with read raises");
        step(GD | FL | RD, 0, 0, C, "R9 failure beats good and read");
        step(RD, 0, 0, C, "R10 read alone arms");
        step(GD, 0, 0, C | LK, "R10 armed good raises");
        step(RFE | ANE, 0, 0, C | LK | RF | AN, "R4 set before reset");
        rst_n = 0;
        step(0, 0, 0, C, "R11 reset clears status");
        rst_n = 1;
        step(GD, 0, 0, C, "R11 reset drops read memory");
        step(0, 0, 0, C, "R2 reserved stay zero");
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule